// File: doc/BRIEF.md
# Two-Channel Wiper Register Controller with I2C Slave Port

This block is the digital front end of a two-channel, 256-step programmable resistor. It listens on an I2C bus as a slave, holds one 8-bit wiper code per channel, and turns each code into a 256-bit one-hot tap select for the analog ladder. It also drives a per-channel flag that opens the top terminal. SCL and SDA are sampled in the system clock domain. Each line passes through a two-flop synchronizer and a short glitch filter before any edge is detected. The slave only ever pulls SDA low, and it does so through an output-enable.

A write frame carries three kinds of byte. The address byte comes first. The instruction byte follows; its most significant bit picks the channel and the next bit is a shutdown flag. Every data byte after that overwrites the chosen channel's wiper. A read frame has only the address byte and then returns the wiper of the channel picked by the most recent instruction. It keeps returning bytes while the master acknowledges.

The 7-bit address is `01011` followed by the two strap inputs. When the parameter `FIXED_ADDR` is set, the address is fixed at `0101111` instead.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {5'b01011, strapAddr[1:0]}, or 7'b0101111 when FIXED_ADDR=1. It acknowledges by pulling SDA low during the ninth SCL pulse. Bit 0 of the address byte selects the direction: 0 for write, 1 for read.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data bits are taken MSB first on the rising edge of SCL.
- R3: In a write frame, the byte after the address is the instruction byte. Bit 7 selects the channel (0 = channel 1, 1 = channel 2) and bit 6 is the shutdown flag. Bits 5..0 have no effect. The new channel and flag apply only once all eight bits of the instruction have been received.
- R4: Each data byte after the instruction is acknowledged and written into the selected channel's wiper. Further data bytes in the same frame overwrite that same wiper.
- R5: A read frame returns the wiper of the channel selected by the latest instruction byte. A write frame that stops right after the instruction is enough to select the channel for a later read.
- R6: While the shutdown flag is 1, termAOpen1 and termAOpen2 are 1 and both tap selects are forced to bit 0. Stored codes are kept and can still be written. Once the flag is cleared, the taps follow the stored codes again.
- R7: After reset, both wipers hold 0x80, channel 1 is selected, and shutdown is clear.
- R8: In a read, the slave sends another byte after each master acknowledge. After a master not-acknowledge it releases SDA and sends nothing more until the next START.
- R9: A START or STOP in the middle of a byte abandons the frame without writing the partial byte. A START begins a new address byte.
- R10: After a non-matching address, the slave drives no acknowledge and changes no register until the next START.
- R11: Outside shutdown, tapSel1 and tapSel2 each have exactly one bit set, at the index equal to the channel's wiper code.
- R12: The slave changes its SDA output-enable only while the filtered SCL is low. The only exception is releasing SDA after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| strapAddr | input | 2 | Low two address bits from board straps |
| wiperCode1 | output | 8 | Stored code of channel 1 |
| wiperCode2 | output | 8 | Stored code of channel 2 |
| tapSel1 | output | 256 | One-hot tap select of channel 1 |
| tapSel2 | output | 256 | One-hot tap select of channel 2 |
| termAOpen1 | output | 1 | Channel 1 top terminal open (shutdown) |
| termAOpen2 | output | 1 | Channel 2 top terminal open (shutdown) |

## Verification
The checks assume the bus is slow compared with the system clock. Every SCL high and low phase, and every SDA move, must last longer than the synchronizer plus filter delay, so that the filtered copies keep the order of edges on the wire. They also assume the master moves SDA only while SCL is low, except when it forms a START or STOP. The bench holds each quarter of a bit for ten system clocks, far above that delay, and changes SDA only in the low quarter. The random frames vary channel, shutdown flag, junk instruction bits, data bytes and read lengths, all inside those rules.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int NUM_TAPS = 1 << CODE_W;
  localparam int CNT_W    = 4;
  localparam logic [4:0] ADDR_BASE  = 5'b01011;
  localparam logic [6:0] ADDR_FIXED = 7'b0101111;

  typedef enum logic [2:0] {
    ST_IGNORE, ST_ADDR, ST_INSTR, ST_DATA, ST_READ
  } ctrlState_t;

  typedef struct packed {
    logic shiftRx;
    logic loadInstr;
    logic writeWiper;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/dpot_bus_filter.sv
module dpot_bus_filter #(
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      runCnt   <= '0;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_CYCLES - 1)) begin
        runCnt   <= '0;
        cleanOut <= syncQ[1];
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter bit FIXED_ADDR = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [1:0]        strapAddr,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strobe,
  output logic              sdaOe,
  output logic              busStart,
  output logic              busStop
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  ctrlState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackPhase, ackDrv, isRead, masterAck;
  logic             sclPrev, sdaPrev;
  logic             sclRise, sclFall, byteDone, ackEnd, addrMatch;
  logic [6:0]       myAddr;

  assign myAddr    = FIXED_ADDR ? ADDR_FIXED : {ADDR_BASE, strapAddr};
  assign addrMatch = (rxByte[BYTE_W-1:1] == myAddr);
  assign sclRise   = sclF & ~sclPrev;
  assign sclFall   = ~sclF & sclPrev;
  assign busStart  = sclF & sclPrev & sdaPrev & ~sdaF;
  assign busStop   = sclF & sclPrev & ~sdaPrev & sdaF;
  assign byteDone  = sclFall && !ackPhase && bitCnt == LAST_BIT && state != ST_IGNORE;
  assign ackEnd    = sclFall && ackPhase && state != ST_IGNORE;

  always_comb begin
    strobe            = '0;
    strobe.shiftRx    = sclRise && !ackPhase && state != ST_IGNORE;
    strobe.loadInstr  = byteDone && state == ST_INSTR;
    strobe.writeWiper = byteDone && state == ST_DATA;
    strobe.loadTx     = ackEnd && ((state == ST_ADDR && isRead) ||
                                   (state == ST_READ && masterAck));
    strobe.shiftTx    = sclFall && state == ST_READ && !ackPhase &&
                        bitCnt != '0 && bitCnt != LAST_BIT;
  end

  assign sdaOe = ackDrv | (state == ST_READ && !ackPhase && !txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IGNORE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      ackDrv    <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      if (busStart || busStop) begin
        state    <= busStart ? ST_ADDR : ST_IGNORE;
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        ackDrv   <= 1'b0;
      end else if (state != ST_IGNORE) begin
        if (sclRise) begin
          if (!ackPhase) bitCnt <= bitCnt + 1'b1;
          else if (state == ST_READ) masterAck <= ~sdaF;
        end
        if (byteDone) begin
          ackPhase <= 1'b1;
          unique case (state)
            ST_ADDR: begin
              if (addrMatch) begin
                ackDrv <= 1'b1;
                isRead <= rxByte[0];
              end else begin
                state    <= ST_IGNORE;
                ackPhase <= 1'b0;
              end
            end
            ST_INSTR, ST_DATA: ackDrv <= 1'b1;
            default: ;
          endcase
        end else if (ackEnd) begin
          ackPhase <= 1'b0;
          bitCnt   <= '0;
          ackDrv   <= 1'b0;
          unique case (state)
            ST_ADDR:  state <= isRead ? ST_READ : ST_INSTR;
            ST_INSTR: state <= ST_DATA;
            ST_READ:  if (!masterAck) state <= ST_IGNORE;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dpot_datapath.sv
module dpot_datapath
  import dpot_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                sdaF,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                txBit,
  output logic [CODE_W-1:0]   wiperCode1,
  output logic [CODE_W-1:0]   wiperCode2,
  output logic [NUM_TAPS-1:0] tapSel1,
  output logic [NUM_TAPS-1:0] tapSel2,
  output logic                termAOpen1,
  output logic                termAOpen2
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0]   wiperReg [NUM_CH];
  logic [NUM_TAPS-1:0] tapArr   [NUM_CH];
  logic [BYTE_W-1:0]   txShift;
  logic                chanSel, sdFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      chanSel <= 1'b0;
      sdFlag  <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) wiperReg[i] <= MID_CODE;
    end else begin
      if (strobe.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaF};
      if (strobe.loadInstr) begin
        chanSel <= rxByte[BYTE_W-1];
        sdFlag  <= rxByte[BYTE_W-2];
      end
      if (strobe.writeWiper) wiperReg[chanSel] <= rxByte;
      if (strobe.loadTx)       txShift <= wiperReg[chanSel];
      else if (strobe.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign txBit = txShift[BYTE_W-1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tap
    assign tapArr[g] = sdFlag ? NUM_TAPS'(1) : (NUM_TAPS'(1) << wiperReg[g]);
  end

  assign wiperCode1 = wiperReg[0];
  assign wiperCode2 = wiperReg[1];
  assign tapSel1    = tapArr[0];
  assign tapSel2    = tapArr[1];
  assign termAOpen1 = sdFlag;
  assign termAOpen2 = sdFlag;
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_pkg::*;
#(
  parameter bit FIXED_ADDR  = 1'b0,
  parameter int FILT_CYCLES = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic [1:0]          strapAddr,
  output logic [CODE_W-1:0]   wiperCode1,
  output logic [CODE_W-1:0]   wiperCode2,
  output logic [NUM_TAPS-1:0] tapSel1,
  output logic [NUM_TAPS-1:0] tapSel2,
  output logic                termAOpen1,
  output logic                termAOpen2
);
  logic              sclF, sdaF, txBit, busStart, busStop;
  logic [BYTE_W-1:0] rxByte;
  dpStrobe_t         strobe;

  dpot_bus_filter #(.FILT_CYCLES(FILT_CYCLES)) u_sclFilt (
    .clk(clk), .rstN(rstN), .rawIn(sclIn), .cleanOut(sclF));
  dpot_bus_filter #(.FILT_CYCLES(FILT_CYCLES)) u_sdaFilt (
    .clk(clk), .rstN(rstN), .rawIn(sdaIn), .cleanOut(sdaF));

  dpot_ctrl #(.FIXED_ADDR(FIXED_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .strapAddr(strapAddr),
    .rxByte(rxByte), .txBit(txBit), .strobe(strobe), .sdaOe(sdaOe),
    .busStart(busStart), .busStop(busStop));

  dpot_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaF(sdaF), .rxByte(rxByte),
    .txBit(txBit), .wiperCode1(wiperCode1), .wiperCode2(wiperCode2),
    .tapSel1(tapSel1), .tapSel2(tapSel2),
    .termAOpen1(termAOpen1), .termAOpen2(termAOpen2));
endmodule

// File: rtl/dpot_i2c_slave_chk.sv
module dpot_i2c_slave_chk
  import dpot_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                sclF,
  input logic                busStart,
  input logic                busStop,
  input logic                sdaOe,
  input logic [CODE_W-1:0]   wiperCode1,
  input logic [CODE_W-1:0]   wiperCode2,
  input logic [NUM_TAPS-1:0] tapSel1,
  input logic [NUM_TAPS-1:0] tapSel2,
  input logic                termAOpen1,
  input logic                termAOpen2
);
  assert_midscale_reset_R7: assert property (@(posedge clk)
    $rose(rstN) |-> (wiperCode1 == 8'h80 && wiperCode2 == 8'h80 && !termAOpen1));

  assert_tap_one_hot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel1) == 1 && $countones(tapSel2) == 1);

  assert_tap_at_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    !termAOpen1 |-> (tapSel1[wiperCode1] && tapSel2[wiperCode2]));

  assert_shutdown_tap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (termAOpen1 || termAOpen2) |-> (tapSel1[0] && tapSel2[0]));

  assert_wiper_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(wiperCode1) || !$stable(wiperCode2)) |-> !sclF);

  assert_sda_change_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!sclF || $past(busStart || busStop)));
endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .busStart(busStart), .busStop(busStop),
  .sdaOe(sdaOe), .wiperCode1(wiperCode1), .wiperCode2(wiperCode2),
  .tapSel1(tapSel1), .tapSel2(tapSel2),
  .termAOpen1(termAOpen1), .termAOpen2(termAOpen2));

// File: tb/dpot_i2c_slave_bench.sv
module dpot_i2c_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdaOe, aOpen1, aOpen2;
  logic [7:0] code1, code2;
  logic [255:0] tap1, tap2;
  wire sdaLine = mSda & ~sdaOe;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] expW [2];
  logic expSel = 1'b0, expSd = 1'b0;

  always #10 clk = ~clk;

  dpot_i2c_slave u_dpot_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapAddr(strap), .wiperCode1(code1), .wiperCode2(code2),
    .tapSel1(tap1), .tapSel2(tap2), .termAOpen1(aOpen1), .termAOpen2(aOpen2));

  function automatic logic [255:0] expTap(input logic [7:0] c, input logic sd);
    return sd ? 256'd1 : (256'd1 << c);
  endfunction

  function automatic logic [7:0] addrByte(input logic [1:0] s, input logic rd);
    return {5'b01011, s, rd};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ();
  endtask

  task automatic bitCycle(input logic b, output logic s);
    mSda = b; waitQ(); mScl = 1'b1; waitQ(); s = sdaLine; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitCycle(d[i], s);
    bitCycle(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s);
      d[i] = s;
    end
    bitCycle(~giveAck, s);
  endtask

  task automatic checkPorts(input string req);
    check(req, "wiperCode1", 256'(code1), 256'(expW[0]));
    check(req, "wiperCode2", 256'(code2), 256'(expW[1]));
    check(req, "termAOpen1", 256'(aOpen1), 256'(expSd));
    check(req, "termAOpen2", 256'(aOpen2), 256'(expSd));
    check(req, "tapSel1", tap1, expTap(expW[0], expSd));
    check(req, "tapSel2", tap2, expTap(expW[1], expSd));
  endtask

  task automatic writeFrame(input logic ch, input logic sd, input logic [5:0] junk,
                            input int n, input logic [7:0] d0, input bit rnd);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    check("R1", "write address ack", 256'(a), 256'(1));
    sendByte({ch, sd, junk}, a);
    check("R3", "instruction ack", 256'(a), 256'(1));
    expSel = ch; expSd = sd;
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : d0 + 8'(i);
      sendByte(d, a);
      check("R4", "data ack", 256'(a), 256'(1));
      expW[ch] = d;
    end
    busStop();
  endtask

  task automatic readFrame(input int n);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte(addrByte(strap, 1'b1), a);
    check("R1", "read address ack", 256'(a), 256'(1));
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, d);
      check("R5", "read data", 256'(d), 256'(expW[expSel]));
    end
    check("R8", "sda released after nack", 256'(sdaOe), 256'(0));
    busStop();
  endtask

  initial begin
    logic a, s;
    logic [7:0] d;
    void'($urandom(32'd1234));
    expW[0] = 8'h80; expW[1] = 8'h80;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    checkPorts("R7");
    check("R7", "sdaOe idle", 256'(sdaOe), 256'(0));
    readFrame(1);   // R7: channel 1 selected after reset

    writeFrame(1'b1, 1'b0, 6'h00, 1, 8'h33, 0);
    checkPorts("R4");
    writeFrame(1'b0, 1'b0, 6'h15, 3, 8'hFD, 0);
    checkPorts("R4");
    writeFrame(1'b1, 1'b0, 6'h3F, 0, 8'h00, 0);   // R3 junk bits, R5 pointer only
    checkPorts("R3");
    readFrame(2);   // R8 ack then nack

    writeFrame(1'b0, 1'b1, 6'h00, 1, 8'h10, 0);   // R6 shutdown with write
    checkPorts("R6");
    writeFrame(1'b0, 1'b0, 6'h00, 0, 8'h00, 0);
    checkPorts("R6");

    // R10: foreign address
    busStart();
    sendByte(8'h50, a);
    check("R10", "foreign address nack", 256'(a), 256'(0));
    sendByte(8'h80, a);
    check("R10", "no ack after mismatch", 256'(a), 256'(0));
    sendByte(8'h44, a);
    busStop();
    checkPorts("R10");

    // R9: repeated START in the middle of a data byte
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    sendByte(8'h80, a);
    expSel = 1'b1;
    for (int i = 0; i < 4; i++) bitCycle(1'b0, s);
    busStart();
    sendByte(addrByte(strap, 1'b1), a);
    check("R9", "address after restart ack", 256'(a), 256'(1));
    recvByte(1'b0, d);
    check("R9", "read after abort", 256'(d), 256'(expW[1]));
    busStop();
    checkPorts("R9");

    // R2/R9: STOP in the middle of a data byte
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    sendByte(8'h00, a);
    expSel = 1'b0;
    for (int i = 0; i < 3; i++) bitCycle(1'b1, s);
    busStop();
    checkPorts("R2");
    readFrame(1);

    // R1: strap change moves the address
    strap = 2'b01;
    busStart();
    sendByte(addrByte(2'b10, 1'b0), a);
    check("R1", "old strap address nack", 256'(a), 256'(0));
    busStop();
    writeFrame(1'b1, 1'b0, 6'h2A, 1, 8'hC3, 0);
    checkPorts("R1");

    for (int it = 0; it < 36; it++) begin
      if ($urandom_range(0, 2) == 0) readFrame($urandom_range(1, 2));
      else writeFrame(1'($urandom), 1'($urandom_range(0, 3) == 0), 6'($urandom),
                      $urandom_range(0, 2), 8'h00, 1);
      checkPorts("R11");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule